// File: doc/BRIEF.md
# Paged CSR Access Decoder

This block sits between a narrow control-and-status port, 4 KB of byte address space, and an internal register map with a 16-bit byte address (64 KB). Most of the narrow space maps one to one onto the bottom of the internal map. The top quarter of the narrow space, addresses 0xC00 to 0xFFF, is a window. An access that lands in the window is sent to an internal address made from a 6-bit page number and the low ten bits of the request address. The page number is held in a control register. That register also holds two enable bits for programmed I/O: one for the system-bus side and one for the link side.

Software reaches a high register in two steps. It first writes the page number (bits 15:10 of the target offset) into the control register, keeping the enable bits as they were. It then reads or writes through the window. The block accepts one request per cycle and returns one response on the cycle after each accepted request. In this project the internal map holds the control register, a low bank of plain registers and a high bank of plain registers. The high bank can only be reached through paging.

Top module: `csr_paged_decoder`

## Requirements
- R1: Out of reset, rsp_valid is 0, amba_pio_en and link_pio_en are 0, page_sel is 0, and every bank register reads 0. req_ready is 1 from the first clock edge after reset is released.
- R2: The control register sits at internal address 0x0808. In a write to it, data bit 0 sets amba_pio_en, bit 1 sets link_pio_en and bits 18:13 set page_sel. A read returns these fields at the same bit positions and 0 in every other bit.
- R3: A request address in 0xC00..0xFFF (both top bits set) goes to internal address {page_sel, addr[9:0]}.
- R4: Any other request address goes to the internal address with the same value, zero-extended to 16 bits.
- R5: A page change made by an accepted write takes effect for the request accepted on the very next cycle.
- R6: A read of an internal address that holds no register returns 0. A write to such an address changes no register.
- R7: Each request accepted with req_valid and req_ready high gives exactly one rsp_valid pulse on the next cycle. rsp_valid is 0 in every other cycle. Read data appears on rsp_rdata in that cycle, and write responses carry 0.
- R8: The control register can also be written through the window (page 2, offset 0x008). The new page applies to the next request.
- R9: Address bits 1:0 do not take part in decoding. Every register is a 32-bit word.
- R10: The low bank holds LO_WORDS words at internal 0x0000 + 4*i. The high bank holds HI_WORDS words at HI_BASE + 4*i (default 0x4BA0). Each register returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte address in the narrow space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request accepted on the previous cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| amba_pio_en | output | 1 | System-bus-side programmed I/O enable |
| link_pio_en | output | 1 | Link-side programmed I/O enable |
| page_sel | output | 6 | Current page number |

## Verification
The hardest case to reach is the one where the page field changes and the next request goes through the window on the very next cycle. Only a back-to-back pair of requests, with req_valid never dropping, shows whether the new page was used. The bench drives such pairs in both directions, to a high page and back to page 0. The same risk arises when the control register rewrites its own page through the window. The bench covers that by writing the register through page 2 and then reading the high bank at once.

// File: rtl/csr_page_pkg.sv
package csr_page_pkg;
  localparam int CSR_AW = 12;
  localparam int PG_W   = 6;
  localparam int OFS_W  = 10;
  localparam int IA_W   = PG_W + OFS_W;
  localparam int DW     = 32;
  localparam int PG_LSB = 13;
  localparam int WA_W   = IA_W - 2;
  localparam logic [IA_W-1:0] CTRL_IADDR = 16'h0808;

  typedef logic [IA_W-1:0] iaddr_t;
  typedef logic [PG_W-1:0] page_t;

  typedef struct packed {
    page_t page;
    logic  link_en;
    logic  amba_en;
  } ctrl_t;

  function automatic logic in_window(input logic [CSR_AW-1:0] a);
    return &a[CSR_AW-1:OFS_W];
  endfunction

  function automatic iaddr_t map_addr(input page_t pg, input logic [CSR_AW-1:0] a);
    if (in_window(a)) return {pg, a[OFS_W-1:0]};
    return {{(IA_W-CSR_AW){1'b0}}, a};
  endfunction

  function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
    logic [DW-1:0] w;
    w = '0;
    w[0] = c.amba_en;
    w[1] = c.link_en;
    w[PG_LSB +: PG_W] = c.page;
    return w;
  endfunction

  function automatic ctrl_t word_to_ctrl(input logic [DW-1:0] w);
    ctrl_t c;
    c.amba_en = w[0];
    c.link_en = w[1];
    c.page    = w[PG_LSB +: PG_W];
    return c;
  endfunction
endpackage

// File: rtl/csr_page_ctrl.sv
module csr_page_ctrl
  import csr_page_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  output ctrl_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_val;
  end
endmodule

// File: rtl/csr_addr_xlate.sv
module csr_addr_xlate
  import csr_page_pkg::*;
(
  input  page_t             page,
  input  logic [CSR_AW-1:0] addr,
  output iaddr_t            iaddr,
  output logic              windowed
);
  always_comb begin
    windowed = in_window(addr);
    iaddr    = map_addr(page, addr);
  end
endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank
  import csr_page_pkg::*;
#(
  parameter logic [IA_W-1:0] BASE  = '0,
  parameter int              WORDS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WA_W-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  output logic            hit,
  output logic [DW-1:0]   rdata
);
  localparam logic [WA_W-1:0] BASE_W = BASE[IA_W-1:2];

  logic [WORDS-1:0]  sel;
  logic [DW-1:0]     word_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign sel[i] = (waddr == BASE_W + WA_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 word_q[i] <= '0;
      else if (wr_en && sel[i])   word_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++)
      if (sel[i]) rdata = rdata | word_q[i];
    hit = |sel;
  end
endmodule

// File: rtl/csr_paged_decoder.sv
module csr_paged_decoder
  import csr_page_pkg::*;
#(
  parameter int              LO_WORDS = 8,
  parameter logic [IA_W-1:0] HI_BASE  = 16'h4BA0,
  parameter int              HI_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSR_AW-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              amba_pio_en,
  output logic              link_pio_en,
  output logic [PG_W-1:0]   page_sel
);
  // named internal events
  logic          accept;
  logic          hit_window;
  iaddr_t        xlate_addr;
  logic          hit_ctrl;
  logic          ctrl_wr;
  logic          lo_hit, hi_hit, map_hit;
  logic [DW-1:0] lo_rd, hi_rd, rd_mux;
  ctrl_t         ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_ready <= 1'b0;
    else        req_ready <= 1'b1;
  end

  assign accept = req_valid && req_ready;

  csr_addr_xlate u_xlate (
    .page     (ctrl_q.page),
    .addr     (req_addr),
    .iaddr    (xlate_addr),
    .windowed (hit_window)
  );

  assign hit_ctrl = (xlate_addr[IA_W-1:2] == CTRL_IADDR[IA_W-1:2]);
  assign ctrl_wr  = accept && req_write && hit_ctrl;

  csr_page_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wr_val (word_to_ctrl(req_wdata)),
    .ctrl_q (ctrl_q)
  );

  csr_reg_bank #(.BASE('0), .WORDS(LO_WORDS)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept && req_write),
    .waddr (xlate_addr[IA_W-1:2]),
    .wdata (req_wdata),
    .hit   (lo_hit),
    .rdata (lo_rd)
  );

  csr_reg_bank #(.BASE(HI_BASE), .WORDS(HI_WORDS)) u_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept && req_write),
    .waddr (xlate_addr[IA_W-1:2]),
    .wdata (req_wdata),
    .hit   (hi_hit),
    .rdata (hi_rd)
  );

  assign map_hit = hit_ctrl || lo_hit || hi_hit;

  always_comb begin
    if (hit_ctrl)    rd_mux = ctrl_to_word(ctrl_q);
    else if (lo_hit) rd_mux = lo_rd;
    else if (hi_hit) rd_mux = hi_rd;
    else             rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_rdata <= (accept && !req_write) ? rd_mux : '0;
    end
  end

  assign amba_pio_en = ctrl_q.amba_en;
  assign link_pio_en = ctrl_q.link_en;
  assign page_sel    = ctrl_q.page;
endmodule

// File: rtl/csr_paged_decoder_chk.sv
module csr_paged_decoder_chk
  import csr_page_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [CSR_AW-1:0] req_addr,
  input logic [PG_W-1:0]   wpage,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_rdata,
  input logic [PG_W-1:0]   page_sel,
  input logic              ctrl_wr,
  input logic              hit_window,
  input logic [IA_W-1:0]   xlate_addr,
  input logic              map_hit
);
  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R7
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (page_sel == $past(wpage)));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(page_sel));

  // R3
  window_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_window |-> (xlate_addr[IA_W-1:OFS_W] == page_sel &&
                    xlate_addr[OFS_W-1:0] == req_addr[OFS_W-1:0]));

  // R4
  direct_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_window |-> (xlate_addr[IA_W-1:CSR_AW] == '0 &&
                     xlate_addr[CSR_AW-1:0] == req_addr));

  // R6
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !map_hit) |=> (rsp_rdata == '0));
endmodule

bind csr_paged_decoder csr_paged_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .wpage      (req_wdata[18:13]),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .page_sel   (page_sel),
  .ctrl_wr    (ctrl_wr),
  .hit_window (hit_window),
  .xlate_addr (xlate_addr),
  .map_hit    (map_hit)
);

// File: tb/tb_csr_paged_decoder.sv
module tb_csr_paged_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        amba_pio_en, link_pio_en;
  logic [5:0]  page_sel;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  csr_paged_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .amba_pio_en(amba_pio_en),
    .link_pio_en(link_pio_en), .page_sel(page_sel)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic a, input logic l, input logic [5:0] pg);
    return (32'(pg) << 13) | (32'(l) << 1) | 32'(a);
  endfunction

  function automatic logic [11:0] win(input logic [15:0] target);
    return 12'hC00 | {2'b00, target[9:0]};
  endfunction

  // one request; response checked on the next edge
  task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    chk(rsp_valid === 1'b1, "R7 rsp_valid after accept", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata;
    if (wr) chk(rsp_rdata === 32'd0, "R7 write response data", rsp_rdata, 32'd0);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(rsp_valid === 1'b0, "R7 no rsp when idle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] r;
    acc(1'b0, a, '0, r);
    chk(r === exp, tag, r, exp);
  endtask

  task automatic set_ctrl(input logic a, input logic l, input logic [5:0] pg);
    logic [31:0] r;
    acc(1'b1, 12'h808, ctrl_word(a, l, pg), r);
  endtask

  task automatic t_reset();
    #1;
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    chk({amba_pio_en, link_pio_en} === 2'b00, "R1 enables in reset", 32'({amba_pio_en, link_pio_en}), 0);
    chk(page_sel === 6'd0, "R1 page in reset", 32'(page_sel), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    rd_exp(12'h008, 32'd0, "R1 low bank zero");
    rd_exp(12'h808, 32'd0, "R1 ctrl zero");
    idle();
  endtask

  task automatic t_ctrl();
    logic [31:0] r;
    acc(1'b1, 12'h808, 32'hFFFF_FFFF, r);
    #1;
    chk({amba_pio_en, link_pio_en} === 2'b11, "R2 enables set", 32'({amba_pio_en, link_pio_en}), 3);
    chk(page_sel === 6'h3F, "R2 page field", 32'(page_sel), 32'h3F);
    rd_exp(12'h808, ctrl_word(1, 1, 6'h3F), "R2 ctrl readback masks other bits");
    set_ctrl(1'b0, 1'b1, 6'h00);
    rd_exp(12'h808, ctrl_word(0, 1, 6'h00), "R2 ctrl partial");
    chk(amba_pio_en === 1'b0 && link_pio_en === 1'b1, "R2 enable pins", 32'({amba_pio_en, link_pio_en}), 1);
    idle();
  endtask

  task automatic t_direct_window();
    logic [31:0] r;
    acc(1'b1, 12'h004, 32'hB0B0_0004, r);
    rd_exp(12'h004, 32'hB0B0_0004, "R4 R10 direct low bank");
    rd_exp(12'h006, 32'hB0B0_0004, "R9 low address bits ignored");
    rd_exp(win(16'h0004), 32'hB0B0_0004, "R3 window page 0");
    set_ctrl(1'b0, 1'b1, 6'h12);
    acc(1'b1, win(16'h4BA0), 32'hAAAA_0001, r);
    acc(1'b1, win(16'h4BA4), 32'hCCCC_0002, r);
    rd_exp(win(16'h4BA0), 32'hAAAA_0001, "R3 R10 high bank word0");
    rd_exp(win(16'h4BAC), 32'd0, "R10 high bank word3 untouched");
    rd_exp(12'h004, 32'hB0B0_0004, "R4 direct ignores page");
    idle();
  endtask

  task automatic t_back_to_back();
    logic [31:0] r;
    set_ctrl(1'b0, 1'b1, 6'h00);
    acc(1'b1, 12'h808, ctrl_word(0, 1, 6'h12), r);
    acc(1'b0, win(16'h4BA4), '0, r);
    chk(r === 32'hCCCC_0002, "R5 new page used next cycle", r, 32'hCCCC_0002);
    acc(1'b1, 12'h808, ctrl_word(0, 1, 6'h00), r);
    acc(1'b0, win(16'h0004), '0, r);
    chk(r === 32'hB0B0_0004, "R5 back to page 0 next cycle", r, 32'hB0B0_0004);
    idle();
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    rd_exp(12'h100, 32'd0, "R6 direct unmapped reads zero");
    acc(1'b1, 12'h100, 32'hDEAD_BEEF, r);
    rd_exp(12'h100, 32'd0, "R6 unmapped write ignored");
    rd_exp(12'h004, 32'hB0B0_0004, "R6 mapped reg unchanged");
    set_ctrl(1'b0, 1'b0, 6'h3F);
    acc(1'b1, win(16'hFFF0), 32'h1234_5678, r);
    rd_exp(win(16'hFFF0), 32'd0, "R6 paged unmapped zero");
    idle();
  endtask

  task automatic t_self_page();
    logic [31:0] r;
    set_ctrl(1'b0, 1'b0, 6'h02);
    acc(1'b1, win(16'h0808), ctrl_word(1, 0, 6'h12), r);
    acc(1'b0, win(16'h4BA0), '0, r);
    chk(r === 32'hAAAA_0001, "R8 page written via window applies next", r, 32'hAAAA_0001);
    #1;
    chk(page_sel === 6'h12 && amba_pio_en === 1'b1, "R8 ctrl fields via window",
        32'({amba_pio_en, page_sel}), 32'h52);
    idle();
  endtask

  initial begin
    t_reset();
    t_ctrl();
    t_direct_window();
    t_back_to_back();
    t_unmapped();
    t_self_page();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule